// File: doc/BRIEF.md
# Priority Sync Source Selector

This block takes three digitized, polarity-normalized sync streams from a display front end: a sync-on-green stream, a composite or horizontal sync stream, and a separate vertical sync stream. It also takes a fourth stream, the vertical pulse that an external separator has already recovered from composite sync. A presence flag comes with each candidate source. From the flags and a three-level mode input, the block picks one horizontal source and one vertical source. The horizontal source drives a complementary pair of horizontal outputs and the output that feeds the external vertical integrator. The vertical source drives the vertical output.

The block also forms a clamp pulse on the selected horizontal stream. The mode decides which edge of that stream starts the pulse, and a cycle-count input sets the pulse width. A change of source waits until both the old and the new stream are low, so no output ever carries a clipped pulse.

Top module: `sync_src_select`

## Requirements
- R1: The mode input is 2 bits wide. 00 selects mode L, 01 selects mode M, 10 selects mode H, and 11 behaves exactly like 10.
- R2: In mode L or H, the horizontal outputs follow the composite/H stream when it is flagged present. Otherwise they follow the green stream when green is present. With neither present they stay idle.
- R3: In mode M, the horizontal outputs follow the green stream only. The composite/H stream is ignored, and without green the outputs stay idle (positive output 0, negative output 1, integrator feed 0, no clamp pulse).
- R4: Every output is registered, one clock cycle after the input it reflects. The negative horizontal output is always the complement of the positive one, and the integrator feed equals the positive one.
- R5: While the separate vertical stream is present, the vertical output follows it in every mode.
- R6: Without a separate vertical stream, the vertical output follows the recovered vertical pulse. In modes L and H this needs green or composite/H to be present; in mode M it needs green. Otherwise the vertical output stays 0.
- R7: In mode H (10 or 11) with composite/H present, the clamp pulse starts in the same cycle as the rising edge of the positive horizontal output.
- R8: In all other cases (mode H with green only, mode M, mode L), the clamp pulse starts in the same cycle as the falling edge of the positive horizontal output.
- R9: The clamp pulse stays high for exactly the number of cycles on the width input, sampled at the starting edge. A width of 0 produces no pulse.
- R10: A qualifying edge that arrives while the clamp pulse is high is ignored. It neither extends nor restarts the pulse.
- R11: A horizontal or vertical source change takes effect only in a cycle where both the currently selected stream and the newly wanted stream are low. A pulse in progress on the old source is therefore passed through to its end.
- R12: During reset and right after it, no source is selected. The outputs read positive horizontal 0, negative horizontal 1, integrator feed 0, vertical 0, clamp 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Priority/edge mode: 00 L, 01 M, 10 H, 11 H |
| green_sync | input | 1 | Sync-on-green stream, active high |
| green_present | input | 1 | Green stream carries valid sync |
| comph_sync | input | 1 | Composite/horizontal sync stream, active high |
| comph_present | input | 1 | Composite/H stream carries valid sync |
| vsep_sync | input | 1 | Separate vertical sync stream, active high |
| vsep_present | input | 1 | Separate vertical stream carries valid sync |
| vrec_sync | input | 1 | Vertical pulse recovered from composite sync |
| clamp_cycles | input | CLAMP_CW | Clamp pulse width in clock cycles |
| hd_pos | output | 1 | Selected horizontal sync, positive |
| hd_neg | output | 1 | Selected horizontal sync, negative |
| vint_out | output | 1 | Selected horizontal sync toward the external vertical integrator |
| vd_out | output | 1 | Selected vertical sync, positive |
| clamp_out | output | 1 | Clamp pulse |

## Verification
The bench flips presence flags while the old source is mid-pulse. A selector that switched at once would clip the pulse on the horizontal or vertical output. It runs mode 11 next to mode 10 and composite/H with green in mode M, which catch a decoder that treats 11 as L or lets composite through in M. Clamp widths of 0, 1 and several cycles, with edges packed closer than the pulse width, expose an off-by-one counter, a pulse that fires at width 0, and a pulse that restarts on a later edge. Leading- and trailing-edge cases in each mode catch a clamp that fires on the wrong edge.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

   typedef enum logic [1:0] {
      MODE_L  = 2'b00,
      MODE_M  = 2'b01,
      MODE_H  = 2'b10,
      MODE_HX = 2'b11
   } ssel_mode_e;

   // horizontal candidate indices (index 0 means nothing selected)
   localparam logic [1:0] HS_NONE  = 2'd0;
   localparam logic [1:0] HS_GREEN = 2'd1;
   localparam logic [1:0] HS_COMP  = 2'd2;

   // vertical candidate indices
   localparam logic [1:0] VS_NONE = 2'd0;
   localparam logic [1:0] VS_SEP  = 2'd1;
   localparam logic [1:0] VS_REC  = 2'd2;

   function automatic logic mode_green_only(input logic [1:0] m);
      return ssel_mode_e'(m) == MODE_M;
   endfunction

   function automatic logic mode_lead_capable(input logic [1:0] m);
      return (ssel_mode_e'(m) == MODE_H) || (ssel_mode_e'(m) == MODE_HX);
   endfunction

endpackage

// File: rtl/ssel_policy.sv
module ssel_policy
   import ssel_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       green_present,
   input  logic       comph_present,
   input  logic       vsep_present,
   output logic [1:0] h_want,
   output logic       h_lead,
   output logic [1:0] v_want
);

   logic green_only;
   logic lead_ok;
   logic rec_ok;

   always_comb begin
      green_only = mode_green_only(mode);
      lead_ok    = mode_lead_capable(mode);

      if (green_only)
         h_want = green_present ? HS_GREEN : HS_NONE;
      else if (comph_present)
         h_want = HS_COMP;
      else if (green_present)
         h_want = HS_GREEN;
      else
         h_want = HS_NONE;

      h_lead = lead_ok && comph_present;

      rec_ok = green_only ? green_present : (green_present || comph_present);
      if (vsep_present)
         v_want = VS_SEP;
      else if (rec_ok)
         v_want = VS_REC;
      else
         v_want = VS_NONE;
   end

endmodule

// File: rtl/ssel_quiet_mux.sv
module ssel_quiet_mux #(
   parameter int NSRC  = 3,
   parameter int TAG_W = 1,
   localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src,
   input  logic [SW-1:0]    want_idx,
   input  logic [TAG_W-1:0] want_tag,
   output logic [SW-1:0]    sel_idx,
   output logic [TAG_W-1:0] sel_tag,
   output logic             pick_now,
   output logic             out_q
);

   if (NSRC < 2) begin : g_bad_nsrc
      $error("ssel_quiet_mux: NSRC must be at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ssel_quiet_mux: TAG_W must be at least 1");
   end

   logic [NSRC-1:0] hit_sel;
   logic [NSRC-1:0] hit_want;
   logic            want_lvl;
   logic            swap;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit_sel[i]  = (sel_idx  == SW'(i)) & src[i];
      assign hit_want[i] = (want_idx == SW'(i)) & src[i];
   end

   assign pick_now = |hit_sel;
   assign want_lvl = |hit_want;
   assign swap     = !pick_now && !want_lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_idx <= '0;
         sel_tag <= '0;
         out_q   <= 1'b0;
      end else begin
         out_q <= pick_now;
         if (swap) begin
            sel_idx <= want_idx;
            sel_tag <= want_tag;
         end
      end
   end

   AST_SWAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_idx != $past(sel_idx)) |-> (out_q == 1'b0)); // R11

endmodule

// File: rtl/ssel_clamp_gen.sv
module ssel_clamp_gen #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl_now,
   input  logic          lvl_prev,
   input  logic          lead,
   input  logic [CW-1:0] width,
   output logic          clamp_q
);

   if (CW < 1) begin : g_bad_cw
      $error("ssel_clamp_gen: CW must be at least 1");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] width_q;
   logic [CW-1:0] run_cnt;
   logic          trig;

   assign trig = lead ? (lvl_now && !lvl_prev) : (!lvl_now && lvl_prev);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clamp_q <= 1'b0;
         cnt     <= '0;
         width_q <= '0;
      end else if (clamp_q) begin
         if (cnt == '0) clamp_q <= 1'b0;
         else           cnt     <= cnt - 1'b1;
      end else if (trig && (width != '0)) begin
         clamp_q <= 1'b1;
         cnt     <= width - 1'b1;
         width_q <= width;
      end
   end

   // run length of the current high phase, kept for the width check
   always_ff @(posedge clk) begin
      if (!rst_n) run_cnt <= '0;
      else        run_cnt <= clamp_q ? run_cnt + 1'b1 : '0;
   end

   AST_CLAMP_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      clamp_q |-> (run_cnt < width_q)); // R9

   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (clamp_q && cnt != '0) |=> (clamp_q && cnt == $past(cnt) - 1'b1)); // R10

endmodule

// File: rtl/sync_src_select.sv
module sync_src_select
   import ssel_pkg::*;
#(
   parameter int CLAMP_CW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode,
   input  logic                green_sync,
   input  logic                green_present,
   input  logic                comph_sync,
   input  logic                comph_present,
   input  logic                vsep_sync,
   input  logic                vsep_present,
   input  logic                vrec_sync,
   input  logic [CLAMP_CW-1:0] clamp_cycles,
   output logic                hd_pos,
   output logic                hd_neg,
   output logic                vint_out,
   output logic                vd_out,
   output logic                clamp_out
);

   localparam int NSRC = 3;
   localparam int SW   = $clog2(NSRC);

   if (CLAMP_CW < 2 || CLAMP_CW > 16) begin : g_bad_clamp_cw
      $error("sync_src_select: CLAMP_CW must lie in 2..16");
   end

   logic [1:0]      h_want;
   logic [1:0]      v_want;
   logic            h_lead_want;
   logic [NSRC-1:0] h_src;
   logic [NSRC-1:0] v_src;
   logic [SW-1:0]   h_sel;
   logic [SW-1:0]   v_sel;
   logic            h_lead;
   logic            v_tag_unused;
   logic            h_pick;
   logic            v_pick;
   logic            h_out;
   logic            hd_neg_q;

   assign h_src = {comph_sync, green_sync, 1'b0};
   assign v_src = {vrec_sync,  vsep_sync,  1'b0};

   ssel_policy u_policy (
      .mode          (mode),
      .green_present (green_present),
      .comph_present (comph_present),
      .vsep_present  (vsep_present),
      .h_want        (h_want),
      .h_lead        (h_lead_want),
      .v_want        (v_want)
   );

   ssel_quiet_mux #(.NSRC(NSRC), .TAG_W(1)) u_hmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (h_src),
      .want_idx (SW'(h_want)),
      .want_tag (h_lead_want),
      .sel_idx  (h_sel),
      .sel_tag  (h_lead),
      .pick_now (h_pick),
      .out_q    (h_out)
   );

   ssel_quiet_mux #(.NSRC(NSRC), .TAG_W(1)) u_vmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (v_src),
      .want_idx (SW'(v_want)),
      .want_tag (1'b0),
      .sel_idx  (v_sel),
      .sel_tag  (v_tag_unused),
      .pick_now (v_pick),
      .out_q    (vd_out)
   );

   ssel_clamp_gen #(.CW(CLAMP_CW)) u_clamp (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_now  (h_pick),
      .lvl_prev (h_out),
      .lead     (h_lead),
      .width    (clamp_cycles),
      .clamp_q  (clamp_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) hd_neg_q <= 1'b1;
      else        hd_neg_q <= ~h_pick;
   end

   assign hd_pos   = h_out;
   assign hd_neg   = hd_neg_q;
   assign vint_out = h_out;

   AST_HD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      hd_neg == ~hd_pos); // R4

   AST_HD_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      hd_pos |-> $past(comph_sync || green_sync)); // R2

   AST_VD_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      vd_out |-> $past(vsep_sync || vrec_sync)); // R5

   AST_CLAMP_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clamp_out) |-> !$stable(hd_pos)); // R7

   AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (h_sel != 2'd3) && (v_sel != 2'd3)); // R11

endmodule

// File: tb/tb_sync_src_select.sv
`timescale 1ns/1ps
module tb_sync_src_select;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode;
   logic       green_sync, green_present, comph_sync, comph_present;
   logic       vsep_sync, vsep_present, vrec_sync;
   logic [7:0] clamp_cycles;
   logic       hd_pos, hd_neg, vint_out, vd_out, clamp_out;

   always #5 clk = ~clk;

   sync_src_select #(.CLAMP_CW(8)) dut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .green_sync(green_sync), .green_present(green_present),
      .comph_sync(comph_sync), .comph_present(comph_present),
      .vsep_sync(vsep_sync), .vsep_present(vsep_present),
      .vrec_sync(vrec_sync), .clamp_cycles(clamp_cycles),
      .hd_pos(hd_pos), .hd_neg(hd_neg), .vint_out(vint_out),
      .vd_out(vd_out), .clamp_out(clamp_out)
   );

   typedef struct {
      logic [4:0] v;
      string      tag;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;

   // stimulus settings held between steps
   logic [1:0] b_mode;
   logic       b_gp, b_cp, b_vp;
   int         b_w;

   // reference state derived from the requirements
   int   m_hsel, m_vsel, m_ccnt;
   logic m_hlead, m_hprev, m_cact;

   task automatic step(input string tag, input logic g, input logic c,
                       input logic vs, input logic vr);
      logic is_m, is_h, hl, hnow, vnow, trig, hw_lvl, vw_lvl;
      int   hw, vw;
      exp_t e;
      @(negedge clk);
      mode = b_mode; green_present = b_gp; comph_present = b_cp;
      vsep_present = b_vp; clamp_cycles = 8'(b_w);
      green_sync = g; comph_sync = c; vsep_sync = vs; vrec_sync = vr;

      is_m = (b_mode == 2'b01);
      is_h = b_mode[1];
      hw   = is_m ? (b_gp ? 1 : 0) : (b_cp ? 2 : (b_gp ? 1 : 0));
      hl   = is_h && b_cp;
      hnow = (m_hsel == 1) ? g : (m_hsel == 2) ? c : 1'b0;
      trig = m_hlead ? (hnow && !m_hprev) : (!hnow && m_hprev);
      if (m_cact) begin
         if (m_ccnt == 0) m_cact = 1'b0;
         else             m_ccnt--;
      end else if (trig && b_w != 0) begin
         m_cact = 1'b1;
         m_ccnt = b_w - 1;
      end
      hw_lvl = (hw == 1) ? g : (hw == 2) ? c : 1'b0;
      if (!hnow && !hw_lvl) begin
         m_hsel  = hw;
         m_hlead = hl;
      end
      m_hprev = hnow;

      vw     = b_vp ? 1 : ((is_m ? b_gp : (b_gp || b_cp)) ? 2 : 0);
      vnow   = (m_vsel == 1) ? vs : (m_vsel == 2) ? vr : 1'b0;
      vw_lvl = (vw == 1) ? vs : (vw == 2) ? vr : 1'b0;
      if (!vnow && !vw_lvl) m_vsel = vw;

      e.v   = {hnow, !hnow, hnow, vnow, m_cact};
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic burst(input string tag, input int n,
                        input int cper, input int chi, input int gper, input int ghi,
                        input int vper, input int vhi, input int rper, input int rhi);
      for (int i = 0; i < n; i++)
         step(tag, (i % gper) < ghi, (i % cper) < chi, (i % vper) < vhi, (i % rper) < rhi);
   endtask

   // monitor: pop one expected item per driven cycle, after the edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         cur = q.pop_front();
         checks++;
         if ({hd_pos, hd_neg, vint_out, vd_out, clamp_out} !== cur.v) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (hd_pos hd_neg vint vd clamp)",
                     cur.tag, {hd_pos, hd_neg, vint_out, vd_out, clamp_out}, cur.v);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      mode = 2'b00; green_sync = 0; green_present = 0; comph_sync = 0;
      comph_present = 0; vsep_sync = 0; vsep_present = 0; vrec_sync = 0;
      clamp_cycles = 8'd0;
      m_hsel = 0; m_vsel = 0; m_ccnt = 0;
      m_hlead = 0; m_hprev = 0; m_cact = 0;
      repeat (4) @(negedge clk);
      // R12: reset state
      checks++;
      if ({hd_pos, hd_neg, vint_out, vd_out, clamp_out} !== 5'b01000) begin
         fails++;
         $display("FAIL R12: actual %b expected %b",
                  {hd_pos, hd_neg, vint_out, vd_out, clamp_out}, 5'b01000);
      end
      rst_n = 1'b1;

      // R2: composite/H wins over green in mode L
      b_mode = 2'b00; b_gp = 1; b_cp = 1; b_vp = 1; b_w = 4;
      burst("R2", 60, 10, 2, 7, 3, 30, 4, 25, 6);
      b_cp = 0;
      burst("R2", 60, 10, 2, 7, 3, 30, 4, 25, 6);
      // R3: mode M uses green only
      b_mode = 2'b01; b_cp = 1; b_gp = 1;
      burst("R3", 60, 9, 4, 8, 2, 30, 4, 25, 6);
      b_gp = 0; b_vp = 0;
      burst("R3", 60, 9, 4, 8, 2, 30, 4, 25, 6);
      // R6: mode M without green or separate V gives idle vertical
      burst("R6", 40, 9, 4, 8, 2, 13, 4, 11, 5);
      // R5 / R6: vertical source choice
      b_mode = 2'b00; b_gp = 1; b_cp = 1; b_vp = 1;
      burst("R5", 60, 10, 2, 7, 3, 17, 5, 23, 7);
      b_vp = 0;
      burst("R6", 60, 10, 2, 7, 3, 17, 5, 23, 7);
      b_mode = 2'b01; b_cp = 0;
      burst("R6", 60, 10, 2, 7, 3, 17, 5, 23, 7);
      // R7: leading-edge clamp in mode H, R1: 11 behaves as 10
      b_mode = 2'b10; b_cp = 1; b_gp = 1; b_w = 3;
      burst("R7", 60, 12, 4, 7, 3, 30, 4, 25, 6);
      b_mode = 2'b11;
      burst("R1", 60, 12, 4, 7, 3, 30, 4, 25, 6);
      // R8: trailing edge with green only in H, and in L
      b_mode = 2'b10; b_cp = 0;
      burst("R8", 60, 12, 4, 9, 3, 30, 4, 25, 6);
      b_mode = 2'b00; b_cp = 1;
      burst("R8", 60, 12, 4, 9, 3, 30, 4, 25, 6);
      // R9: widths 1, 0, 7
      b_mode = 2'b10; b_w = 1;
      burst("R9", 50, 12, 4, 9, 3, 30, 4, 25, 6);
      b_w = 0;
      burst("R9", 50, 12, 4, 9, 3, 30, 4, 25, 6);
      b_w = 7;
      burst("R9", 50, 12, 4, 9, 3, 30, 4, 25, 6);
      // R10: edges closer than the pulse width are ignored
      b_w = 20;
      burst("R10", 80, 6, 2, 9, 3, 30, 4, 25, 6);
      b_mode = 2'b00;
      burst("R10", 80, 6, 2, 9, 3, 30, 4, 25, 6);
      // R4: output pair under mode 11 traffic
      b_mode = 2'b11; b_w = 2;
      burst("R4", 40, 5, 2, 4, 1, 9, 3, 7, 2);
      // R11: presence flags flip while the selected source is mid-pulse
      b_mode = 2'b00; b_gp = 1; b_w = 3;
      for (int i = 0; i < 120; i++) begin
         b_cp = ((i / 20) % 2) == 0;
         b_vp = ((i / 15) % 2) == 0;
         step("R11", (i % 7) < 3, (i % 9) < 5, (i % 11) < 6, (i % 13) < 4);
      end
      b_gp = 0; b_cp = 0; b_vp = 0;
      burst("R11", 20, 9, 5, 7, 3, 11, 6, 13, 4);

      repeat (4) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule